// File: doc/BRIEF.md
# Clock-Phase Gated Word RAM

This block is a small word-organised random access memory whose read/write control line is the system clock itself. Each clock period has two halves. While the line is low the memory reads, and while it is high the memory writes. Every stored bit is a gated single-bit cell with set/reset behaviour. The cell captures data only when its row is selected during the write half. It drives its output only when its row is selected during the read half.

An address decoder with an enable input picks one row. Write data bit k fans out to bit k of every row. Output bit k is the OR of the bit-k outputs of all the cells in that column. Unselected cells drive zero, so this OR gives the addressed word without a multiplexer. The output bus is all zeros for the whole write half and whenever the enable is low. Callers change the address, enable and data only during the read half. The size is set by the word count and the word width: the default is 4 words of 2 bits, and 256 words of 16 bits is also supported. The contents have no reset.

Top module: `phase_ram`

## Requirements
- R1: While `rw_phase` is 0 (read half) and `addr_en` is 1, `dout` equals the word most recently written at `addr`.
- R2: When `addr_en` is 0 no row is selected. When `addr_en` is 1 exactly one row, the one numbered by `addr`, is selected.
- R3: While `rw_phase` is 1 (write half), `dout` is all zeros whatever the memory holds.
- R4: During a write half with `addr_en` at 1, every bit of `din` is stored into the word at `addr`, all bits at once, and reads back unchanged later.
- R5: With `addr_en` at 0, a read half returns all zeros and a write half leaves every word unchanged.
- R6: During a read half the stored contents cannot change, even when `din` changes while a row is selected.
- R7: A write to one address leaves the words at all other addresses unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rw_phase | input | 1 | Read/write phase; driven by the system clock, 0 = read, 1 = write |
| addr_en | input | 1 | Enable of the address decoder |
| addr | input | $clog2(WORDS) | Word address |
| din | input | WIDTH | Data to store during the write half |
| dout | output | WIDTH | Column-ORed read data, zero outside an enabled read half |

## Verification
The assertions check at every input change that the output is zero during the write half (R3) and while the decoder is disabled (R5). They also check that the row selects are empty or one-hot in step with the enable (R2), and that an enabled read shows the held word at the address (R1). Whether a write really lands in the right word, whether a disabled or read-half write corrupts anything, and whether a write leaves neighbours untouched (R4 to R7) shows only over time. The bench's reference model shows these by writing distinct patterns, toggling data mid-read, and reading every word back.

// File: rtl/phase_ram_pkg.sv
package phase_ram_pkg;
    parameter int DEF_WORDS = 4;
    parameter int DEF_WIDTH = 2;

    function automatic int addr_bits(input int words);
        return (words > 1) ? $clog2(words) : 1;
    endfunction
endpackage

// File: rtl/phase_ram_decoder.sv
module phase_ram_decoder #(
    parameter int WORDS = phase_ram_pkg::DEF_WORDS,
    localparam int AW = phase_ram_pkg::addr_bits(WORDS)
) (
    input  logic             enable,
    input  logic [AW-1:0]    addr,
    output logic [WORDS-1:0] row_sel
);
    always_comb begin
        row_sel = '0;
        if (enable) begin
            for (int r = 0; r < WORDS; r++) begin
                if (AW'(r) == addr) row_sel[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/phase_ram_cell.sv
module phase_ram_cell (
    input  logic sel,
    input  logic wr_phase,
    input  logic d,
    output logic held,
    output logic q_out
);
    logic set_in;
    logic clr_in;

    // set and clear come from d and ~d, so both are never 1 together
    assign set_in = sel & wr_phase & d;
    assign clr_in = sel & wr_phase & ~d;

    always_latch begin
        if (set_in | clr_in) held <= set_in;
    end

    assign q_out = sel & ~wr_phase & held;
endmodule

// File: rtl/phase_ram_colmerge.sv
module phase_ram_colmerge #(
    parameter int WORDS = phase_ram_pkg::DEF_WORDS,
    parameter int WIDTH = phase_ram_pkg::DEF_WIDTH
) (
    input  logic [WORDS-1:0][WIDTH-1:0] cell_q,
    output logic [WIDTH-1:0]            col_or
);
    always_comb begin
        col_or = '0;
        for (int r = 0; r < WORDS; r++) begin
            col_or = col_or | cell_q[r];
        end
    end
endmodule

// File: rtl/phase_ram.sv
module phase_ram #(
    parameter int WORDS = phase_ram_pkg::DEF_WORDS,
    parameter int WIDTH = phase_ram_pkg::DEF_WIDTH,
    localparam int AW = phase_ram_pkg::addr_bits(WORDS)
) (
    input  logic             rw_phase,
    input  logic             addr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WORDS-1:0]            row_sel;
    logic [WORDS-1:0][WIDTH-1:0] held_bits;
    logic [WORDS-1:0][WIDTH-1:0] cell_q;

    phase_ram_decoder #(.WORDS(WORDS)) u_dec (
        .enable  (addr_en),
        .addr    (addr),
        .row_sel (row_sel)
    );

    for (genvar r = 0; r < WORDS; r++) begin : g_row
        for (genvar c = 0; c < WIDTH; c++) begin : g_col
            phase_ram_cell u_cell (
                .sel      (row_sel[r]),
                .wr_phase (rw_phase),
                .d        (din[c]),
                .held     (held_bits[r][c]),
                .q_out    (cell_q[r][c])
            );
        end
    end

    phase_ram_colmerge #(.WORDS(WORDS), .WIDTH(WIDTH)) u_merge (
        .cell_q (cell_q),
        .col_or (dout)
    );
endmodule

// File: rtl/phase_ram_chk.sv
module phase_ram_chk #(
    parameter int WORDS = phase_ram_pkg::DEF_WORDS,
    parameter int WIDTH = phase_ram_pkg::DEF_WIDTH,
    localparam int AW = phase_ram_pkg::addr_bits(WORDS)
) (
    input logic                        rw_phase,
    input logic                        addr_en,
    input logic [AW-1:0]               addr,
    input logic [WIDTH-1:0]            dout,
    input logic [WORDS-1:0]            row_sel,
    input logic [WORDS-1:0][WIDTH-1:0] held
);
    always_comb begin
        if (!$isunknown({rw_phase, addr_en, addr})) begin
            if (rw_phase)
                AST_WRITE_HALF_ZERO: assert (dout == '0); // R3
            if (!addr_en)
                AST_IDLE_ZERO: assert (dout == '0); // R5
            if (!addr_en)
                AST_NO_ROW: assert (row_sel == '0); // R2
            if (addr_en)
                AST_ONE_ROW: assert ($countones(row_sel) == 1 && row_sel[addr]); // R2
            if (addr_en && !rw_phase)
                AST_READ_WORD: assert (dout === held[addr]); // R1
        end
    end
endmodule

bind phase_ram phase_ram_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .rw_phase (rw_phase),
    .addr_en  (addr_en),
    .addr     (addr),
    .dout     (dout),
    .row_sel  (row_sel),
    .held     (held_bits)
);

// File: tb/tb_phase_ram.sv
`timescale 1ns/1ps
module tb_phase_ram;
    localparam int WORDS = 4;
    localparam int WIDTH = 2;
    localparam int AW = 2;

    logic             rw_phase = 1'b0;
    logic             addr_en = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;

    int checks = 0;
    int fails = 0;
    logic [WIDTH-1:0] ref_mem [WORDS];
    bit               known [WORDS];

    phase_ram #(.WORDS(WORDS), .WIDTH(WIDTH)) dut (
        .rw_phase (rw_phase),
        .addr_en  (addr_en),
        .addr     (addr),
        .din      (din),
        .dout     (dout)
    );

    // 125 MHz: low half reads, high half writes
    always #4 rw_phase = ~rw_phase;

    task automatic check(input string tag, input logic [WIDTH-1:0] exp);
        checks++;
        if (dout !== exp) begin
            fails++;
            $display("FAIL %s: dout=%b expected=%b at %0t", tag, dout, exp, $time);
        end
    endtask

    // one full period: inputs set early in the read half, din swapped mid-read,
    // the write half then stores din_w if enabled
    task automatic cycle(input logic en, input int a,
                         input logic [WIDTH-1:0] din_r,
                         input logic [WIDTH-1:0] din_w, input string tag);
        @(negedge rw_phase);
        #1;
        addr_en = en;
        addr = AW'(a);
        din = din_r;
        #1;
        if (!en) check(tag, '0);
        else if (known[a]) check(tag, ref_mem[a]);
        #0.5;
        din = din_w;
        #0.5;
        if (!en) check("R6", '0);
        else if (known[a]) check("R6", ref_mem[a]);
        @(posedge rw_phase);
        if (en) begin
            ref_mem[a] = din_w;
            known[a] = 1'b1;
        end
        #2;
        check("R3", '0);
    endtask

    initial begin
        logic [WIDTH-1:0] v;
        int seed;
        for (int i = 0; i < WORDS; i++) known[i] = 1'b0;
        // initial state: decoder disabled, output quiet (R5)
        cycle(1'b0, 0, '1, '1, "R5");
        cycle(1'b0, 3, '0, '1, "R5");
        // distinct pattern into every word (R4)
        for (int a = 0; a < WORDS; a++) cycle(1'b1, a, '0, ~WIDTH'(a), "R4");
        for (int a = 0; a < WORDS; a++) cycle(1'b1, a, ref_mem[a], ref_mem[a], "R4");
        // disabled writes must not land (R5)
        for (int a = 0; a < WORDS; a++) cycle(1'b0, a, WIDTH'(a), WIDTH'(a + 1), "R5");
        for (int a = 0; a < WORDS; a++) cycle(1'b1, a, ref_mem[a], ref_mem[a], "R5");
        // overwrite one row, neighbours intact (R7)
        cycle(1'b1, 1, ref_mem[1], ~ref_mem[1], "R4");
        for (int a = 0; a < WORDS; a++) cycle(1'b1, a, ref_mem[a], ref_mem[a], "R7");
        // din toggles during the read half, contents hold (R6)
        cycle(1'b1, 2, ~ref_mem[2], ~ref_mem[2], "R6");
        cycle(1'b1, 2, ref_mem[2], ref_mem[2], "R6");
        // mixed traffic against the model (R1)
        seed = 7;
        for (int k = 0; k < 40; k++) begin
            seed = (seed * 73 + 19) % 1021;
            v = WIDTH'(seed >> 3);
            if (seed % 3 == 0) cycle(1'b1, seed % WORDS, v, v, "R1");
            else if (seed % 3 == 1) cycle(1'b1, seed % WORDS,
                                          ref_mem[seed % WORDS], ref_mem[seed % WORDS], "R1");
            else cycle(1'b0, seed % WORDS, v, ~v, "R5");
        end
        for (int a = 0; a < WORDS; a++) cycle(1'b1, a, ref_mem[a], ref_mem[a], "R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: expected=finished actual=hung");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule